// File: doc/BRIEF.md
# Block Hamming Code Generator for NAND Data

This block accumulates a 22-bit Hamming code over a stream of bytes that pass through a NAND flash data port. It computes one code for every block of 256 bytes. The code lets software locate and correct one flipped bit in the block, or detect that more than one bit is wrong. Correction itself is done in software. This block only produces the code.

Before each block, the host pulses a clear input. Every byte that crosses the data port, whether it is read from the flash or written to it, is presented with a one-cycle strobe. Bytes arrive in index order, so the first byte after the clear is byte 0. The three code bytes are returned in one 32-bit word. The code follows the usual small-page layout:

- The sixteen line parities are taken over the byte-parity of each byte. They are grouped by the bits of the byte's index.
- The six column parities are taken over bit groups of the XOR of all bytes.
- All stored bits are inverted, so an erased (all-0xFF) block reads back as all ones.

Top module: `smc_hamming_ecc`

## Requirements
- R1: Let bp(i) be the XOR of the 8 bits of byte i, where i is the byte index 0 to 255 counted from the last clear. For each index bit k (0 to 7), line parity L(2k) is the XOR of bp(i) over all bytes whose index bit k is 0. L(2k+1) is the same XOR over all bytes whose index bit k is 1. Code byte A is the inverse of {L7..L0}. Code byte B is the inverse of {L15..L8}. In both, the higher-numbered parity is in the more significant bit.
- R2: Let c be the XOR of all accepted bytes. The column parities are:
  - C0 = c0^c2^c4^c6
  - C1 = c1^c3^c5^c7
  - C2 = c0^c1^c4^c5
  - C3 = c2^c3^c6^c7
  - C4 = c0^c1^c2^c3
  - C5 = c4^c5^c6^c7

  Code byte C is the inverse of {C5,C4,C3,C2,C1,C0,0,0}, so its two low bits always read 1.
- R3: A cycle with the clear input high and the strobe low empties the block. On the next cycle the word reads 0x00FFFFFF, and the next strobed byte becomes byte 0.
- R4: The result word places code byte A in bits 23:16, B in bits 15:8 and C in bits 7:0. Bits 31:24 read zero.
- R5: A block of 256 bytes that are all 0xFF yields the word 0x00FFFFFF.
- R6: A strobed byte changes the result word in the cycle right after its strobe edge.
- R7: After 256 bytes have been accepted, further strobed bytes leave the word unchanged until the next clear.
- R8: When the clear and the strobe are high in the same cycle, the old block is discarded and the byte on the data input becomes byte 0 of the new block.
- R9: After reset the word reads 0x00FFFFFF and the block is empty.
- R10: A cycle with both the strobe and the clear low leaves the word unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, all state on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| byte_stb_i | input | 1 | One-cycle strobe for a byte crossing the data port |
| byte_i | input | 8 | Data byte qualified by the strobe |
| ecc_clr_i | input | 1 | Clear pulse that starts a new block |
| ecc_word_o | output | 32 | Code bytes A, B, C in bits 23:0, bits 31:24 zero |

## Verification
Two situations are hardest to reach from the ports:
- the saturated state, where the byte counter has reached 256 and further strobes must be ignored;
- the cycle in which a clear and a strobe coincide.

The stimulus therefore streams full blocks of random data and then keeps strobing beyond the 256th byte. It also issues clears that carry a byte on the same edge, including one in the middle of a block and one while the block is saturated. A behavioural model rebuilds the code from a queue of the accepted bytes on every clock. Directed single-byte blocks pin down the exact bit positions of the line and column parities.

// File: rtl/nhe_pkg.sv
package nhe_pkg;

   localparam int unsigned BYTE_W   = 8;
   localparam int unsigned COL_N    = 6;
   localparam int unsigned LINE_MAX = 16;
   localparam int unsigned WORD_W   = 32;

   // Column parities over one folded byte, C0 in bit 0.
   function automatic logic [COL_N-1:0] col_fold(input logic [BYTE_W-1:0] c);
      logic [COL_N-1:0] r;
      r[0] = c[0] ^ c[2] ^ c[4] ^ c[6];
      r[1] = c[1] ^ c[3] ^ c[5] ^ c[7];
      r[2] = c[0] ^ c[1] ^ c[4] ^ c[5];
      r[3] = c[2] ^ c[3] ^ c[6] ^ c[7];
      r[4] = c[0] ^ c[1] ^ c[2] ^ c[3];
      r[5] = c[4] ^ c[5] ^ c[6] ^ c[7];
      return r;
   endfunction

endpackage

// File: rtl/nhe_byte_cnt.sv
module nhe_byte_cnt #(
   parameter int unsigned BLOCK_BYTES = 256,
   localparam int unsigned IDX_W = $clog2(BLOCK_BYTES),
   localparam int unsigned CNT_W = IDX_W + 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             stb,
   input  logic             clr,
   output logic             take,
   output logic [IDX_W-1:0] idx,
   output logic             full
);

   localparam logic [CNT_W-1:0] LIMIT = CNT_W'(BLOCK_BYTES);

   logic [CNT_W-1:0] cnt_q;

   assign full = (cnt_q == LIMIT);
   assign take = stb & (clr | ~full);
   assign idx  = clr ? '0 : cnt_q[IDX_W-1:0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (clr) begin
         cnt_q <= CNT_W'(stb);
      end else if (take) begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

   AST_CLEAR_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> cnt_q == CNT_W'($past(stb)));                         // R3
   AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr && stb && !full) |=> cnt_q == $past(cnt_q) + 1'b1);     // R6
   AST_SATURATE: assert property (@(posedge clk) disable iff (!rst_n)
      (full && !clr) |=> full);                                     // R7

endmodule

// File: rtl/nhe_line_acc.sv
module nhe_line_acc #(
   parameter int unsigned IDX_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             take,
   input  logic [IDX_W-1:0] idx,
   input  logic             bpar,
   output logic [IDX_W-1:0] lp_lo,
   output logic [IDX_W-1:0] lp_hi
);

   generate
      for (genvar k = 0; k < IDX_W; k++) begin : g_bit
         logic hit_lo, hit_hi;
         assign hit_lo = take & bpar & ~idx[k];
         assign hit_hi = take & bpar &  idx[k];

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               lp_lo[k] <= 1'b0;
               lp_hi[k] <= 1'b0;
            end else if (clr) begin
               lp_lo[k] <= hit_lo;
               lp_hi[k] <= hit_hi;
            end else begin
               lp_lo[k] <= lp_lo[k] ^ hit_lo;
               lp_hi[k] <= lp_hi[k] ^ hit_hi;
            end
         end
      end
   endgenerate

endmodule

// File: rtl/nhe_col_acc.sv
module nhe_col_acc
   import nhe_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr,
   input  logic              take,
   input  logic [BYTE_W-1:0] din,
   output logic [BYTE_W-1:0] col,
   output logic [COL_N-1:0]  cp
);

   logic [BYTE_W-1:0] gated;
   assign gated = take ? din : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         col <= '0;
      end else if (clr) begin
         col <= gated;
      end else begin
         col <= col ^ gated;
      end
   end

   assign cp = col_fold(col);

endmodule

// File: rtl/nhe_pack.sv
module nhe_pack
   import nhe_pkg::*;
#(
   parameter int unsigned IDX_W = 8
) (
   input  logic [IDX_W-1:0] lp_lo,
   input  logic [IDX_W-1:0] lp_hi,
   input  logic [COL_N-1:0] cp,
   output logic [WORD_W-1:0] word
);

   logic [LINE_MAX-1:0] lp;

   generate
      for (genvar k = 0; k < LINE_MAX / 2; k++) begin : g_line
         if (k < IDX_W) begin : g_used
            assign lp[2*k]   = lp_lo[k];
            assign lp[2*k+1] = lp_hi[k];
         end else begin : g_pad
            assign lp[2*k]   = 1'b0;
            assign lp[2*k+1] = 1'b0;
         end
      end
   endgenerate

   assign word = {8'h00, ~lp[7:0], ~lp[15:8], ~cp, 2'b11};

endmodule

// File: rtl/smc_hamming_ecc.sv
module smc_hamming_ecc
   import nhe_pkg::*;
#(
   parameter int unsigned BLOCK_BYTES = 256,
   parameter int unsigned DATA_W      = 8,
   localparam int unsigned IDX_W      = $clog2(BLOCK_BYTES)
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        byte_stb_i,
   input  logic [7:0]  byte_i,
   input  logic        ecc_clr_i,
   output logic [31:0] ecc_word_o
);

   localparam logic [WORD_W-1:0] EMPTY_WORD = 32'h00FF_FFFF;

   generate
      if (DATA_W != BYTE_W) begin : g_bad_width
         $error("smc_hamming_ecc: DATA_W must be 8");
      end
      if (BLOCK_BYTES < 2 || BLOCK_BYTES > 256 ||
          (BLOCK_BYTES & (BLOCK_BYTES - 1)) != 0) begin : g_bad_block
         $error("smc_hamming_ecc: BLOCK_BYTES must be a power of two from 2 to 256");
      end
   endgenerate

   logic             take, full;
   logic [IDX_W-1:0] idx;
   logic [IDX_W-1:0] lp_lo, lp_hi;
   logic [7:0]       col;
   logic [COL_N-1:0] cp;
   logic             bpar;

   assign bpar = ^byte_i;

   nhe_byte_cnt #(.BLOCK_BYTES(BLOCK_BYTES)) u_cnt (
      .clk  (clk),
      .rst_n(rst_n),
      .stb  (byte_stb_i),
      .clr  (ecc_clr_i),
      .take (take),
      .idx  (idx),
      .full (full)
   );

   nhe_line_acc #(.IDX_W(IDX_W)) u_line (
      .clk  (clk),
      .rst_n(rst_n),
      .clr  (ecc_clr_i),
      .take (take),
      .idx  (idx),
      .bpar (bpar),
      .lp_lo(lp_lo),
      .lp_hi(lp_hi)
   );

   nhe_col_acc u_col (
      .clk  (clk),
      .rst_n(rst_n),
      .clr  (ecc_clr_i),
      .take (take),
      .din  (byte_i),
      .col  (col),
      .cp   (cp)
   );

   nhe_pack #(.IDX_W(IDX_W)) u_pack (
      .lp_lo(lp_lo),
      .lp_hi(lp_hi),
      .cp   (cp),
      .word (ecc_word_o)
   );

   AST_CLEAR_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
      (ecc_clr_i && !byte_stb_i) |=> ecc_word_o == EMPTY_WORD);     // R3
   AST_FULL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (full && !ecc_clr_i) |=> $stable(ecc_word_o));                // R7
   AST_IDLE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
      (!byte_stb_i && !ecc_clr_i) |=> $stable(ecc_word_o));         // R10
   AST_PARITY_AGREE: assert property (@(posedge clk) disable iff (!rst_n)
      (^col) == (lp_lo[0] ^ lp_hi[0]));                             // R1

endmodule

// File: tb/smc_hamming_ecc_tb.sv
module smc_hamming_ecc_tb;

   localparam time CLK_PERIOD = 10ns;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        byte_stb_i = 1'b0;
   logic [7:0]  byte_i = 8'h00;
   logic        ecc_clr_i = 1'b0;
   logic [31:0] ecc_word_o;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;
   byte unsigned blk[$];

   always #(CLK_PERIOD/2) clk = ~clk;

   smc_hamming_ecc u_dut (
      .clk       (clk),
      .rst_n     (rst_n),
      .byte_stb_i(byte_stb_i),
      .byte_i    (byte_i),
      .ecc_clr_i (ecc_clr_i),
      .ecc_word_o(ecc_word_o)
   );

   function automatic logic [31:0] ref_word();
      logic [7:0]  lo, hi, c;
      logic [15:0] lp;
      logic [5:0]  cp;
      lo = '0; hi = '0; c = '0;
      foreach (blk[i]) begin
         logic bp;
         bp = ^blk[i];
         c  = c ^ blk[i];
         for (int k = 0; k < 8; k++) begin
            if (((i >> k) & 1) != 0) hi[k] = hi[k] ^ bp;
            else                     lo[k] = lo[k] ^ bp;
         end
      end
      for (int k = 0; k < 8; k++) begin
         lp[2*k]   = lo[k];
         lp[2*k+1] = hi[k];
      end
      cp[0] = c[0] ^ c[2] ^ c[4] ^ c[6];
      cp[1] = c[1] ^ c[3] ^ c[5] ^ c[7];
      cp[2] = c[0] ^ c[1] ^ c[4] ^ c[5];
      cp[3] = c[2] ^ c[3] ^ c[6] ^ c[7];
      cp[4] = c[0] ^ c[1] ^ c[2] ^ c[3];
      cp[5] = c[4] ^ c[5] ^ c[6] ^ c[7];
      return {8'h00, ~lp[7:0], ~lp[15:8], ~cp, 2'b11};
   endfunction

   task automatic check(input string req, input logic [31:0] exp);
      checks++;
      if (ecc_word_o !== exp) begin
         fails++;
         $display("FAIL %s: actual %08h expected %08h", req, ecc_word_o, exp);
      end
   endtask

   // Called just after a falling edge; drives one cycle and compares
   // with the model at the following falling edge.
   task automatic step(input string req, input bit stb, input bit clr,
                       input logic [7:0] d);
      byte_stb_i = stb;
      ecc_clr_i  = clr;
      byte_i     = d;
      @(posedge clk);
      if (clr) blk.delete();
      if (stb && (clr || blk.size() < 256)) blk.push_back(d);
      @(negedge clk);
      byte_stb_i = 1'b0;
      ecc_clr_i  = 1'b0;
      check(req, ref_word());
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      if (!done) begin
         fails++;
         $display("FAIL watchdog: actual hung expected finished");
         $display("End of test - %0d assertions evaluated, %0d failures",
                  checks + 1, fails);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      check("R9 reset", 32'h00FF_FFFF);
      rst_n = 1'b1;
      @(negedge clk);
      check("R9 after release", 32'h00FF_FFFF);

      // R1 R2 R4 R6: single 0x01 at index 0
      step("R6 first byte", 1'b1, 1'b1, 8'h01);
      check("R1 R2 R4 single bit", 32'h00AA_AAAB);
      step("R10 idle", 1'b0, 1'b0, 8'h5A);
      check("R10 unchanged", 32'h00AA_AAAB);

      // R3: clear alone
      step("R3 clear", 1'b0, 1'b1, 8'h00);
      check("R3 empty", 32'h00FF_FFFF);

      // R5: erased block
      for (int i = 0; i < 256; i++) step("R5 erased", 1'b1, 1'b0, 8'hFF);
      check("R5 erased result", 32'h00FF_FFFF);

      // R7: bytes beyond the block
      for (int i = 0; i < 8; i++) step("R7 overflow", 1'b1, 1'b0, 8'(i * 37 + 1));
      check("R7 still erased", 32'h00FF_FFFF);

      // R8: clear with strobe while saturated
      step("R8 clear+byte", 1'b1, 1'b1, 8'h01);
      check("R8 new block", 32'h00AA_AAAB);

      // R1 R2: random blocks with gaps, over-run, mid-block clear+byte
      for (int b = 0; b < 4; b++) begin
         step("R3 block start", 1'b0, 1'b1, 8'h00);
         for (int i = 0; i < 300; i++) begin
            bit s;
            s = ($urandom_range(0, 3) != 0);
            step("R1 R2 random", s, 1'b0, 8'($urandom));
         end
         for (int i = 0; i < 40; i++) step("R8 restart", 1'b1, (i == 0), 8'($urandom));
      end

      // R1: single byte at a late index (255) to hit every high line parity
      step("R3 clear", 1'b0, 1'b1, 8'h00);
      for (int i = 0; i < 255; i++) step("R1 zeros", 1'b1, 1'b0, 8'h00);
      step("R1 last index", 1'b1, 1'b0, 8'h80);
      check("R1 R2 index 255", 32'h0055_5557);

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

endmodule